// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a slave serial audio port. An external master supplies a bit clock and a left/right frame clock. Both clocks, and the serial input line, are oversampled by the fast system clock `clk`. The receive half turns the serial input into one left and one right 24-bit sample for each frame. The transmit half shifts two 24-bit samples onto the serial output line in the same frame format.

The framing is chosen by inputs held steady during operation:
- the layout: start at the frame-clock edge, end at the frame-clock edge, or I2S;
- the word length: 16, 20 or 24 bits;
- the bit clocks per frame: 48 or 64;
- an option that swaps the active bit-clock edge.

A one-cycle strobe marks each completed stereo pair on the receive side. All samples use a left-aligned convention: the first bit of a word is bit 23, and short words leave the low bits at zero.

Top module: `serial_audio_port`

## Requirements
- R1: With `fmt`=0 (MSB first at the frame edge), the frame clock is high for left. The word's MSB is the bit sampled on the first active bit-clock edge after a frame-clock transition, and the following bits go MSB to LSB. After the next transition the completed words appear on `rx_left`/`rx_right`, with the first received bit in bit 23.
- R2: With `fmt`=2 (I2S), the frame clock is low for left, and the MSB is sampled on the second active edge after the transition. Every other rule is as in R1.
- R3: With `fmt`=1 (LSB at the frame edge), the word's last bit is the one sampled just before the next transition. The start slot is the slots per channel minus the word length. `wlen` 0/1/2 selects 16/20/24 bits. Received words sit with their MSB at bit 23 and the unused low bits at zero.
- R4: With `frame64`=0 there are 24 bit slots per channel (48 per frame), and with 1 there are 32 (64 per frame). An I2S word at 24 slots keeps only 23 bits, so bit 0 reads zero.
- R5: With `bclk_inv`=1 the falling edge of `bclk` is the sampling edge and the rising edge is the launch edge. Results are otherwise identical.
- R6: `frame_strobe` is a one-cycle pulse, issued when a right word is stored and a left word has been stored since the previous pulse. Steady framing gives exactly one pulse per frame.
- R7: `sdout` changes only after a launch (inactive) edge. It carries `tx_left`/`tx_right` in the same slots and bit order that R1 to R4 define for reception, and it is low in every slot outside the word.
- R8: While `rst_n` is low, `rx_left`, `rx_right`, `frame_strobe` and `sdout` are all zero.
- R9: The transmit word of each channel is captured at that channel's first slot. Later changes of `tx_left`/`tx_right` do not alter the word on the line until the next channel start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame (left/right) clock |
| sdin | input | 1 | Serial receive data |
| fmt | input | 2 | 0 MSB at frame edge, 1 LSB at frame edge, 2 I2S, 3 same as 0 |
| wlen | input | 2 | 0 = 16 bits, 1 = 20 bits, 2/3 = 24 bits |
| frame64 | input | 1 | 0 = 48, 1 = 64 bit clocks per frame |
| bclk_inv | input | 1 | Swap the active bit-clock edge |
| tx_left | input | 24 | Left sample to transmit, MSB at bit 23 |
| tx_right | input | 24 | Right sample to transmit, MSB at bit 23 |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| frame_strobe | output | 1 | One-cycle pulse per completed stereo pair |
| sdout | output | 1 | Serial transmit data |

## Verification
The bench keeps the default 24-bit sample width and 6-bit slot counter. It then sweeps every runtime mode: all three layouts, all three word lengths, both frame lengths and both bit-clock polarities. This reaches the LSB-justified start-slot arithmetic at both frame lengths and the truncated I2S word at 48 slots per frame. A transmit input that changes in the middle of a word shows whether the word is held for the whole channel.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int SW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          lrck,
  input  logic          sdin,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  input  logic          frame64,
  input  logic          bclk_inv,
  input  logic [SW-1:0] tx_left,
  input  logic [SW-1:0] tx_right,
  output logic [SW-1:0] rx_left,
  output logic [SW-1:0] rx_right,
  output logic          frame_strobe,
  output logic          sdout
);
  localparam logic [1:0] FMT_LSB = 2'd1;
  localparam logic [1:0] FMT_I2S = 2'd2;

  logic bc_s, bc_d, lr_s, di_s;
  logic lr_last, seen, have_left;
  logic [CW-1:0] cnt, slot_n, half, wbits, start;
  logic [SW-1:0] acc, hold, mask, word, src;
  logic signed [CW+1:0] k;
  logic rise, fall, chg, inword, left_lvl;
  int bp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_s <= 1'b1;
      bc_d <= 1'b1;
      lr_s <= 1'b0;
      di_s <= 1'b0;
    end else begin
      bc_s <= bclk ^ bclk_inv;
      bc_d <= bc_s;
      lr_s <= lrck;
      di_s <= sdin;
    end
  end

  assign rise     = bc_s & ~bc_d;
  assign fall     = ~bc_s & bc_d;
  assign chg      = lr_s != lr_last;
  assign left_lvl = (fmt != FMT_I2S);
  assign half     = frame64 ? CW'(32) : CW'(24);
  assign wbits    = (wlen == 2'd0) ? CW'(16) : (wlen == 2'd1) ? CW'(20) : CW'(SW);
  assign start    = (fmt == FMT_I2S) ? CW'(1) : (fmt == FMT_LSB) ? half - wbits : '0;
  assign slot_n   = chg ? '0 : ((cnt == '1) ? cnt : cnt + 1'b1);

  always_comb begin
    k      = $signed({2'b00, slot_n}) - $signed({2'b00, start});
    inword = (k >= 0) && (k < $signed({2'b00, wbits}));
    bp     = SW - 1 - int'(k);
    mask   = inword ? (SW'(1) << bp) : '0;
  end

  always_ff @(posedge clk) begin
    frame_strobe <= 1'b0;
    if (!rst_n) begin
      lr_last   <= 1'b0;
      cnt       <= '0;
      seen      <= 1'b0;
      have_left <= 1'b0;
      acc       <= '0;
      rx_left   <= '0;
      rx_right  <= '0;
    end else if (rise) begin
      lr_last <= lr_s;
      cnt     <= slot_n;
      acc     <= (chg ? '0 : acc) | (di_s ? mask : '0);
      if (chg) begin
        seen <= 1'b1;
        if (seen) begin
          if (lr_last == left_lvl) begin
            rx_left   <= acc;
            have_left <= 1'b1;
          end else begin
            rx_right  <= acc;
            have_left <= 1'b0;
            frame_strobe <= have_left;
          end
        end
      end
    end
  end

  assign word = (lr_s == left_lvl) ? tx_left : tx_right;
  assign src  = chg ? word : hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      sdout <= 1'b0;
    end else if (fall) begin
      if (chg) hold <= word;
      sdout <= |(src & mask);
    end
  end
endmodule

module serial_audio_port_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_strobe,
  input logic          sdout,
  input logic [SW-1:0] rx_left,
  input logic [SW-1:0] rx_right,
  input logic          rise,
  input logic          fall,
  input logic          chg
);
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);
  a_r6_strobe_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> $past(rise && chg));
  a_r7_sdout_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(fall));
  a_r1_left_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_left) |-> $past(rise && chg));
  a_r1_right_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_right) |-> $past(rise && chg));
endmodule

bind serial_audio_port serial_audio_port_chk #(.SW(SW)) u_chk (.*);

// File: tb/tb_serial_audio_port.sv
module tb_serial_audio_port;
  localparam int HB = 6;

  logic clk = 0, rst_n = 0, bclk = 1, lrck = 0, sdin = 0;
  logic [1:0] fmt = 0, wlen = 0;
  logic frame64 = 0, bclk_inv = 0;
  logic [23:0] tx_left = 0, tx_right = 0, rx_left, rx_right;
  logic frame_strobe, sdout;
  int total = 0, bad = 0, nstb = 0;

  always #4 clk = ~clk;

  serial_audio_port dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdin(sdin),
    .fmt(fmt), .wlen(wlen), .frame64(frame64), .bclk_inv(bclk_inv),
    .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
    .frame_strobe(frame_strobe), .sdout(sdout));

  always @(posedge clk) if (rst_n && frame_strobe) nstb++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wbits_of(input int wl);
    return (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
  endfunction

  function automatic logic slot_bit(input logic [23:0] w, input int s, input int f, input int wl, input int h);
    int st, k, wb;
    wb = wbits_of(wl);
    st = (f == 2) ? 1 : (f == 1) ? h - wb : 0;
    k = s - st;
    if (k >= 0 && k < wb) return w[23-k];
    return 1'b0;
  endfunction

  function automatic logic [23:0] rx_exp(input logic [23:0] w, input int f, input int wl, input int h);
    int wb;
    wb = wbits_of(wl);
    if (f == 2 && wb > h - 1) wb = h - 1;
    return w & (24'hFFFFFF << (24 - wb));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input string req, input int f, input int wl, input bit f64,
                          input bit inv, input logic [23:0] L, input logic [23:0] R, input bit midchg);
    int h, txerr;
    logic [23:0] w;
    logic lvl, got;
    h = f64 ? 32 : 24;
    @(negedge clk);
    rst_n = 0; fmt = f[1:0]; wlen = wl[1:0]; frame64 = f64; bclk_inv = inv;
    tx_left = L; tx_right = R; sdin = 0;
    bclk = 1'b1 ^ inv;
    lrck = (f == 2) ? 1'b1 : 1'b0;
    tick(4);
    // R8: reset state
    chk(rx_left == 0 && rx_right == 0 && sdout == 0 && frame_strobe == 0,
        {req, " R8 reset"}, {rx_left[15:0], 14'd0, sdout, frame_strobe}, 0);
    rst_n = 1;
    tick(4);
    txerr = 0;
    for (int fr = 0; fr < 4; fr++) begin
      if (fr == 2) nstb = 0;
      for (int ch = 0; ch < 2; ch++) begin
        w = ch == 0 ? L : R;
        lvl = (f == 2) ? ch[0] : ~ch[0];
        for (int s = 0; s < h; s++) begin
          bclk = 1'b0 ^ inv;
          lrck = lvl;
          sdin = slot_bit(w, s, f, wl, h);
          if (midchg && fr == 2 && ch == 0 && s == 10) tx_left = ~L;
          tick(HB);
          got = sdout;
          if (fr == 2 && got !== slot_bit(w, s, f, wl, h)) begin
            if (txerr == 0)
              $display("  tx mismatch ch=%0d slot=%0d got=%b", ch, s, got);
            txerr++;
          end
          bclk = 1'b1 ^ inv;
          tick(HB);
        end
        if (ch == 0) tx_left = L;
      end
    end
    tick(8);
    // R7/R9: transmit stream of frame 2
    chk(txerr == 0, {req, " R7 R9 tx stream"}, txerr, 0);
    chk(rx_left == rx_exp(L, f, wl, h), {req, " rx_left"}, rx_left, rx_exp(L, f, wl, h));
    chk(rx_right == rx_exp(R, f, wl, h), {req, " rx_right"}, rx_right, rx_exp(R, f, wl, h));
    // R6: one strobe per steady frame
    chk(nstb == 2, {req, " R6 strobe count"}, nstb, 2);
  endtask

  initial begin
    run_case("R1 msb64",       0, 2, 1, 0, 24'hA5C3F1, 24'h3C0F96, 0);
    run_case("R2 i2s64",       2, 2, 1, 0, 24'h81F00D, 24'h7E0FF2, 0);
    run_case("R3 lsb24",       1, 2, 1, 0, 24'hC0FFEE, 24'h123457, 0);
    run_case("R3 lsb20",       1, 1, 1, 0, 24'h9ABCDF, 24'h55AA31, 0);
    run_case("R3 lsb16",       1, 0, 1, 0, 24'hF0E1D2, 24'h8001FF, 0);
    run_case("R4 msb48",       0, 2, 0, 0, 24'h6D2B19, 24'hB4D2E7, 0);
    run_case("R4 i2s48",       2, 2, 0, 0, 24'hFFFFFF, 24'h8000FF, 0);
    run_case("R4 lsb16_48",    1, 0, 0, 0, 24'h4321AB, 24'hE5E5E5, 0);
    run_case("R5 msb64_inv",   0, 1, 1, 1, 24'h13579B, 24'hECA864, 0);
    run_case("R5 R9 i2s48inv", 2, 0, 0, 1, 24'hDEAD01, 24'h0BEEF0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule